// File: doc/BRIEF.md
# Bus Master Transfer Width Splitter

This block sits on the master side of a bus bridge. It takes one host request at a time and turns it into data phases on an outgoing bus whose data path can be 64 or 32 bits wide. A request is either a single beat of up to eight bytes, picked out by a byte mask inside one aligned doubleword, or a burst of four 64-bit doublewords at consecutive doubleword addresses.

A single beat is always sent as 32-bit phases: one phase for each half of the doubleword that holds enabled bytes. When configuration allows the wide path, a burst starts as 64-bit phases with the wide request raised. The target may refuse the wide width on any phase. That phase then carries only its lower word, and the rest of the burst goes out as 32-bit phases, starting with the upper word of the same doubleword. No byte is lost and none is sent twice. When the wide path is disabled, a burst goes out directly as eight 32-bit phases.

Each phase is offered with a valid flag and completes on the cycle that the target's ready input is high. The phase fields do not change while the target waits.

Top module: `bus_width_splitter`

## Requirements
- R1: After synchronous reset, `ph_valid` is low and `req_ready` is high.
- R2: A single-beat request produces one 32-bit phase for each doubleword half (bytes 0-3 = lower, bytes 4-7 = upper) that holds enabled mask bits, lower half first. An all-zero mask produces one lower-half phase with every byte enable high. `ph_wide` stays low throughout.
- R3: A 32-bit phase carries its word on `ph_data[31:0]`. It drives `ph_be_n[7:4]` = 4'hF and `ph_be_n[3:0]` = the inverted mask bits of its half. Its address is base + 8*beat + 4*half. Addresses rise strictly within a request.
- R4: With `cfg_wide_en` high when a burst is accepted, and with the target acknowledging every phase, the burst goes out as four phases. Each has `ph_wide` high, `ph_be_n` = 8'h00 and the full doubleword, and the address steps by 8.
- R5: A handshake with `ph_wide` high and `tgt_wide_ack` low transfers only the lower word. The remaining data of the burst follows as 32-bit phases, starting with the upper word of the same doubleword. `ph_wide` never rises again within that burst. Every byte of the burst arrives exactly once.
- R6: With `cfg_wide_en` low when a burst is accepted, the burst goes out as eight 32-bit phases, lower word first in each doubleword, and `ph_wide` stays low.
- R7: While `ph_valid` is high and `tgt_ready` is low, `ph_valid`, `ph_wide`, `ph_addr`, `ph_be_n` and `ph_data` hold their values.
- R8: `req_ready` is high only while no request is in progress, and a request is taken on `req_valid` and `req_ready`. Bits [2:0] of `req_addr` are ignored, so a phase address always has bits [2:0] equal to 0 or 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide_en | input | 1 | Allows 64-bit phases for bursts; sampled when a request is accepted |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_burst | input | 1 | 1 = four-doubleword burst, 0 = single beat |
| req_addr | input | AW | Request address; bits [2:0] ignored |
| req_mask | input | 8 | Byte mask for a single beat (bit n = byte n); ignored for bursts |
| req_data | input | 64*BEATS | Request data; doubleword k in bits [64k+63:64k] |
| tgt_ready | input | 1 | Target completes the offered phase this cycle |
| tgt_wide_ack | input | 1 | Target accepts the 64-bit width on the completing phase |
| ph_valid | output | 1 | A phase is being offered |
| ph_wide | output | 1 | The phase asks for a 64-bit transfer |
| ph_addr | output | AW | Phase address |
| ph_be_n | output | 8 | Active-low byte enables |
| ph_data | output | 64 | Phase data |

## Verification
The bench sweeps every one of the 256 single-beat masks. This catches a design that sends an empty half, leaves out a needed one, puts the upper word first or sends an empty mask as no phase at all; any of these shows up as missing, extra or misplaced bytes or a wrong phase count. For bursts, the target refuses the wide width at each of the four beat positions in turn. A design that repeats the refused doubleword, drops its upper word, or widens again later delivers duplicate or missing bytes, or the wrong number of phases. Random target stalls expose phase fields that change while waiting. Bursts with the wide path disabled expose a stray wide request.

// File: rtl/bws_pkg.sv
package bws_pkg;
  localparam int DWORD_BITS = 64;
  localparam int WORD_BITS  = 32;
  localparam int LANE_BYTES = 8;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LOAD = 2'd1,
    SQ_RUN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/bws_req_store.sv
module bws_req_store #(
  parameter int AW    = 32,
  parameter int BEATS = 4,
  localparam int BW   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 capture,
  input  logic                                 in_burst,
  input  logic [AW-1:0]                        in_addr,
  input  logic [7:0]                           in_mask,
  input  logic [bws_pkg::DWORD_BITS*BEATS-1:0] in_data,
  input  logic [BW-1:0]                        rd_beat,
  output logic [AW-1:0]                        base_addr,
  output logic [7:0]                           mask,
  output logic [bws_pkg::DWORD_BITS-1:0]       rd_data
);
  logic [bws_pkg::DWORD_BITS-1:0] beat_mem [BEATS];

  for (genvar b = 0; b < BEATS; b++) begin : g_mem
    always_ff @(posedge clk) begin
      if (capture) beat_mem[b] <= in_data[b*bws_pkg::DWORD_BITS +: bws_pkg::DWORD_BITS];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      mask      <= '0;
    end else if (capture) begin
      base_addr <= in_addr & ~AW'(7);
      mask      <= in_burst ? 8'hFF : in_mask;
    end
  end

  assign rd_data = beat_mem[rd_beat];
endmodule

// File: rtl/bws_phase_seq.sv
module bws_phase_seq #(
  parameter int BEATS = 4,
  localparam int BW   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          in_burst,
  input  logic [7:0]    in_mask,
  input  logic          wide_en,
  input  logic          hs,
  input  logic          wide_ack,
  output logic          idle,
  output logic          load,
  output logic          finish,
  output logic [BW-1:0] nxt_beat,
  output logic          nxt_half,
  output logic          nxt_wide
);
  import bws_pkg::*;

  localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);

  seq_state_e    st;
  logic [BW-1:0] cur_beat;
  logic          cur_half;
  logic          cur_wide;
  logic          s_burst;
  logic          s_hi;

  logic [BW-1:0] adv_beat;
  logic          adv_half;
  logic          adv_wide;
  logic          adv_last;
  logic          in_lo_need;
  logic          in_hi_need;

  assign in_hi_need = in_burst | (|in_mask[7:4]);
  assign in_lo_need = in_burst | (|in_mask[3:0]) | ~(|in_mask[7:4]);

  always_comb begin
    adv_beat = cur_beat;
    adv_half = cur_half;
    adv_wide = cur_wide;
    adv_last = 1'b0;
    if (cur_wide) begin
      if (wide_ack) begin
        adv_beat = cur_beat + BW'(1);
        adv_half = 1'b0;
        adv_last = (cur_beat == LAST_BEAT);
      end else begin
        adv_half = 1'b1;
        adv_wide = 1'b0;
      end
    end else if (!cur_half && s_hi) begin
      adv_half = 1'b1;
    end else begin
      adv_beat = cur_beat + BW'(1);
      adv_half = 1'b0;
      adv_last = !s_burst || (cur_beat == LAST_BEAT);
    end
  end

  assign idle     = (st == SQ_IDLE);
  assign load     = (st == SQ_LOAD) || ((st == SQ_RUN) && hs && !adv_last);
  assign finish   = (st == SQ_RUN) && hs && adv_last;
  assign nxt_beat = (st == SQ_LOAD) ? cur_beat : adv_beat;
  assign nxt_half = (st == SQ_LOAD) ? cur_half : adv_half;
  assign nxt_wide = (st == SQ_LOAD) ? cur_wide : adv_wide;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      cur_beat <= '0;
      cur_half <= 1'b0;
      cur_wide <= 1'b0;
      s_burst  <= 1'b0;
      s_hi     <= 1'b0;
    end else begin
      case (st)
        SQ_IDLE: if (start) begin
          st       <= SQ_LOAD;
          cur_beat <= '0;
          cur_half <= ~in_lo_need;
          cur_wide <= in_burst & wide_en;
          s_burst  <= in_burst;
          s_hi     <= in_hi_need;
        end
        SQ_LOAD: st <= SQ_RUN;
        SQ_RUN: begin
          if (finish) st <= SQ_IDLE;
          else if (hs) begin
            cur_beat <= adv_beat;
            cur_half <= adv_half;
            cur_wide <= adv_wide;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bws_phase_fmt.sv
module bws_phase_fmt #(
  parameter int AW    = 32,
  parameter int BEATS = 4,
  localparam int BW   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic [BW-1:0]                  beat,
  input  logic                           half,
  input  logic                           wide,
  input  logic [AW-1:0]                  base_addr,
  input  logic [7:0]                     mask,
  input  logic [bws_pkg::DWORD_BITS-1:0] word_in,
  output logic [AW-1:0]                  addr,
  output logic [7:0]                     be_n,
  output logic [bws_pkg::DWORD_BITS-1:0] data
);
  import bws_pkg::*;

  always_comb begin
    addr = base_addr + (AW'(beat) << 3) + (AW'(half) << 2);
    if (wide) begin
      be_n = ~mask;
      data = word_in;
    end else if (half) begin
      be_n = {4'hF, ~mask[7:4]};
      data = {{WORD_BITS{1'b0}}, word_in[DWORD_BITS-1:WORD_BITS]};
    end else begin
      be_n = {4'hF, ~mask[3:0]};
      data = {{WORD_BITS{1'b0}}, word_in[WORD_BITS-1:0]};
    end
  end
endmodule

// File: rtl/bus_width_splitter.sv
module bus_width_splitter #(
  parameter int AW    = 32,
  parameter int BEATS = 4,
  localparam int BW   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 cfg_wide_en,
  input  logic                                 req_valid,
  output logic                                 req_ready,
  input  logic                                 req_burst,
  input  logic [AW-1:0]                        req_addr,
  input  logic [7:0]                           req_mask,
  input  logic [bws_pkg::DWORD_BITS*BEATS-1:0] req_data,
  input  logic                                 tgt_ready,
  input  logic                                 tgt_wide_ack,
  output logic                                 ph_valid,
  output logic                                 ph_wide,
  output logic [AW-1:0]                        ph_addr,
  output logic [7:0]                           ph_be_n,
  output logic [bws_pkg::DWORD_BITS-1:0]       ph_data
);
  import bws_pkg::*;

  logic                  accept;
  logic                  hs;
  logic                  load;
  logic                  finish;
  logic                  idle;
  logic [BW-1:0]         nxt_beat;
  logic                  nxt_half;
  logic                  nxt_wide;
  logic [AW-1:0]         base_addr;
  logic [7:0]            mask_q;
  logic [DWORD_BITS-1:0] beat_word;
  logic [AW-1:0]         f_addr;
  logic [7:0]            f_be_n;
  logic [DWORD_BITS-1:0] f_data;

  assign req_ready = idle;
  assign accept    = req_valid && idle;
  assign hs        = ph_valid && tgt_ready;

  bws_req_store #(.AW(AW), .BEATS(BEATS)) u_store (
    .clk       (clk),
    .rst       (rst),
    .capture   (accept),
    .in_burst  (req_burst),
    .in_addr   (req_addr),
    .in_mask   (req_mask),
    .in_data   (req_data),
    .rd_beat   (nxt_beat),
    .base_addr (base_addr),
    .mask      (mask_q),
    .rd_data   (beat_word)
  );

  bws_phase_seq #(.BEATS(BEATS)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .in_burst (req_burst),
    .in_mask  (req_mask),
    .wide_en  (cfg_wide_en),
    .hs       (hs),
    .wide_ack (tgt_wide_ack),
    .idle     (idle),
    .load     (load),
    .finish   (finish),
    .nxt_beat (nxt_beat),
    .nxt_half (nxt_half),
    .nxt_wide (nxt_wide)
  );

  bws_phase_fmt #(.AW(AW), .BEATS(BEATS)) u_fmt (
    .beat      (nxt_beat),
    .half      (nxt_half),
    .wide      (nxt_wide),
    .base_addr (base_addr),
    .mask      (mask_q),
    .word_in   (beat_word),
    .addr      (f_addr),
    .be_n      (f_be_n),
    .data      (f_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_valid <= 1'b0;
      ph_wide  <= 1'b0;
      ph_addr  <= '0;
      ph_be_n  <= '1;
      ph_data  <= '0;
    end else if (load) begin
      ph_valid <= 1'b1;
      ph_wide  <= nxt_wide;
      ph_addr  <= f_addr;
      ph_be_n  <= f_be_n;
      ph_data  <= f_data;
    end else if (finish) begin
      ph_valid <= 1'b0;
      ph_wide  <= 1'b0;
    end
  end
endmodule

// File: rtl/bws_checker.sv
module bws_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          tgt_ready,
  input logic          tgt_wide_ack,
  input logic          ph_valid,
  input logic          ph_wide,
  input logic [AW-1:0] ph_addr,
  input logic [7:0]    ph_be_n,
  input logic [63:0]   ph_data
);
  a_r7_hold_while_wait: assert property (@(posedge clk) disable iff (rst)
    (ph_valid && !tgt_ready) |=> (ph_valid && $stable(ph_wide) && $stable(ph_addr)
                                  && $stable(ph_be_n) && $stable(ph_data)));

  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    ph_valid |-> !req_ready);

  a_r3_narrow_upper_off: assert property (@(posedge clk) disable iff (rst)
    (ph_valid && !ph_wide) |-> (ph_be_n[7:4] == 4'hF));

  a_r4_wide_all_bytes: assert property (@(posedge clk) disable iff (rst)
    (ph_valid && ph_wide) |-> (ph_be_n == 8'h00));

  a_r5_no_rewiden: assert property (@(posedge clk) disable iff (rst)
    (ph_valid && $past(ph_valid) && !$past(ph_wide)) |-> !ph_wide);

  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    (ph_valid && tgt_ready) |=> (!ph_valid ||
      (ph_addr == $past(ph_addr) + (($past(ph_wide) && $past(tgt_wide_ack)) ? AW'(8) : AW'(4)))));

  a_r8_addr_aligned: assert property (@(posedge clk) disable iff (rst)
    ph_valid |-> (ph_addr[1:0] == 2'b00));
endmodule

bind bus_width_splitter bws_checker #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_ready    (req_ready),
  .tgt_ready    (tgt_ready),
  .tgt_wide_ack (tgt_wide_ack),
  .ph_valid     (ph_valid),
  .ph_wide      (ph_wide),
  .ph_addr      (ph_addr),
  .ph_be_n      (ph_be_n),
  .ph_data      (ph_data)
);

// File: tb/bus_width_splitter_tb.sv
module bus_width_splitter_tb;
  localparam int AW    = 32;
  localparam int BEATS = 4;
  localparam int NB    = BEATS * 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_wide_en = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_burst = 1'b0;
  logic [AW-1:0]     req_addr = '0;
  logic [7:0]        req_mask = '0;
  logic [64*BEATS-1:0] req_data = '0;
  logic              tgt_ready = 1'b0;
  logic              tgt_wide_ack = 1'b0;
  logic              ph_valid;
  logic              ph_wide;
  logic [AW-1:0]     ph_addr;
  logic [7:0]        ph_be_n;
  logic [63:0]       ph_data;

  int total = 0;
  int bad   = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5ns clk = ~clk;

  bus_width_splitter #(.AW(AW), .BEATS(BEATS)) u_dut (
    .clk(clk), .rst(rst), .cfg_wide_en(cfg_wide_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_burst(req_burst),
    .req_addr(req_addr), .req_mask(req_mask), .req_data(req_data),
    .tgt_ready(tgt_ready), .tgt_wide_ack(tgt_wide_ack),
    .ph_valid(ph_valid), .ph_wide(ph_wide), .ph_addr(ph_addr),
    .ph_be_n(ph_be_n), .ph_data(ph_data)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int t, input int i);
    return 8'((t * 37 + i * 11 + 5) & 8'hFF);
  endfunction

  function automatic logic [15:0] step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // burst: 0/1; wcfg: cfg_wide_en; decl: phase index the target refuses the wide width (>=BEATS = never)
  // stall: random target stalls
  task automatic run_txn(input int t, input bit burst, input logic [7:0] mask,
                         input bit wcfg, input int decl, input bit stall, input string rq);
    logic [AW-1:0] base;
    logic [7:0]    got_val [NB];
    int            got_cnt [NB];
    bit            exp_on  [NB];
    int            phases, exp_phases, wide_seen, bytes_bad, range_bad;
    int            order_bad, hold_bad, busy_bad, stall_run;
    logic [AW-1:0] prev_addr, first_addr, exp_first;
    logic [AW-1:0] s_addr;
    logic [7:0]    s_be;
    logic [63:0]   s_data;
    bit            s_wide, pend;
    bit            done;
    int            cyc;
    base = AW'(32'h1000_0000 + t * 64);
    for (int i = 0; i < NB; i++) begin
      got_cnt[i] = 0;
      got_val[i] = '0;
      exp_on[i]  = burst ? 1'b1 : ((i < 8) ? mask[i] : 1'b0);
    end
    phases = 0; wide_seen = 0; bytes_bad = 0; range_bad = 0; order_bad = 0;
    hold_bad = 0; busy_bad = 0; stall_run = 0; pend = 0; done = 0;
    prev_addr = '0; first_addr = '0; s_addr = '0; s_be = '0; s_data = '0; s_wide = 0;
    if (burst) exp_phases = !wcfg ? 2 * BEATS : (decl < BEATS ? 2 * BEATS - decl : BEATS);
    else exp_phases = ((|mask[3:0]) || !(|mask[7:4]) ? 1 : 0) + ((|mask[7:4]) ? 1 : 0);
    exp_first = (!burst && !(|mask[3:0]) && (|mask[7:4])) ? base + 4 : base;

    @(negedge clk);
    for (int i = 0; i < NB; i++) req_data[i*8 +: 8] = pat(t, i);
    req_burst = burst;
    req_mask  = mask;
    req_addr  = base | AW'(t % 8);
    cfg_wide_en = wcfg;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_data  = '0;
    req_mask  = ~mask;
    cfg_wide_en = ~wcfg;
    cyc = 0;
    while (!done && cyc < 400) begin
      if (pend) begin
        if (!ph_valid || ph_addr != s_addr || ph_be_n != s_be || ph_data != s_data
            || ph_wide != s_wide) hold_bad++;
      end
      lfsr = step(lfsr);
      tgt_ready    = !stall || lfsr[0] || (stall_run >= 3);
      tgt_wide_ack = (phases != decl);
      if (ph_valid && req_ready) busy_bad++;
      if (ph_valid && tgt_ready) begin
        int rel, n;
        stall_run = 0;
        pend = 0;
        if (ph_wide) wide_seen++;
        if (phases == 0) first_addr = ph_addr;
        else if (ph_addr <= prev_addr) order_bad++;
        prev_addr = ph_addr;
        rel = int'(ph_addr - base);
        n = (ph_wide && tgt_wide_ack) ? 8 : 4;
        for (int j = 0; j < n; j++) begin
          if (!ph_be_n[j]) begin
            if (rel + j < 0 || rel + j >= NB) range_bad++;
            else begin
              got_cnt[rel + j]++;
              got_val[rel + j] = ph_data[j*8 +: 8];
            end
          end
        end
        phases++;
      end else if (ph_valid) begin
        stall_run++;
        pend = 1; s_addr = ph_addr; s_be = ph_be_n; s_data = ph_data; s_wide = ph_wide;
      end
      @(negedge clk);
      cyc++;
      if (req_ready && !ph_valid) done = 1;
    end
    tgt_ready = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if (exp_on[i] && (got_cnt[i] != 1 || got_val[i] != pat(t, i))) bytes_bad++;
      if (!exp_on[i] && got_cnt[i] != 0) bytes_bad++;
    end
    chk(done, rq, "request completes", done, 1);
    chk(phases == exp_phases, rq, "phase count", phases, exp_phases);
    chk(bytes_bad == 0 && range_bad == 0, rq, "byte stream mismatches", bytes_bad + range_bad, 0);
    chk(order_bad == 0, "R3", "address order violations", order_bad, 0);
    chk(hold_bad == 0, "R7", "fields changed during stall", hold_bad, 0);
    chk(busy_bad == 0, "R8", "req_ready high while busy", busy_bad, 0);
    chk(first_addr == exp_first, "R8", "first phase address", first_addr, exp_first);
    if (!burst || !wcfg)
      chk(wide_seen == 0, burst ? "R6" : "R2", "wide phases", wide_seen, 0);
    else
      chk(wide_seen == ((decl < BEATS) ? decl + 1 : BEATS), decl < BEATS ? "R5" : "R4",
          "wide phases", wide_seen, (decl < BEATS) ? decl + 1 : BEATS);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ph_valid == 1'b0, "R1", "ph_valid after reset", ph_valid, 0);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    t = 0;
    // R2 / R3: every single-beat mask, including the empty one
    for (int m = 0; m < 256; m++) begin
      run_txn(t, 1'b0, 8'(m), m[0], BEATS, m[1], "R2");
      t++;
    end
    // R4: wide bursts, no refusal
    for (int s = 0; s < 2; s++) begin
      run_txn(t, 1'b1, 8'h00, 1'b1, BEATS, s[0], "R4");
      t++;
    end
    // R5: refusal at every beat position
    for (int k = 0; k < BEATS; k++) begin
      for (int s = 0; s < 2; s++) begin
        run_txn(t, 1'b1, 8'h00, 1'b1, k, s[0], "R5");
        t++;
      end
    end
    // R6: wide path disabled
    for (int s = 0; s < 2; s++) begin
      run_txn(t, 1'b1, 8'h00, 1'b0, 0, s[0], "R6");
      t++;
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule